// File: doc/BRIEF.md
# Paired PDM Microphone Capture

This block drives the bit clock for an array of digital pulse-density-modulated microphones and recovers one 1-bit stream per microphone. The microphones are wired in pairs. Both members of a pair put their data on the same wire, and one bit clock feeds every microphone. One microphone of each pair is read while the bit clock is low and the other while it is high. The capture logic therefore needs only one input pin for every two microphones.

The bit clock comes from dividing the system clock by an even integer `DIV` with a counter, which gives an exact 50 % duty cycle. With a 98.304 MHz system clock and `DIV = 32`, the bit clock is 3.072 MHz. Decimating that rate by 64 gives 48 kHz audio. Every recovered bit is registered. All microphone bits are presented together, with one valid pulse per bit-clock period, for a downstream decimation filter. `N_PAIRS` sets the number of shared data lines. `DIV` must be even and at least 4.

Top module: `pdm_pair_capture`

## Requirements
- R1: `pdm_clk_o` has a period of exactly `DIV` system cycles. It is low for `DIV/2` cycles and then high for `DIV/2` cycles. The first cycle after reset release is the first low cycle.
- R2: While `rst_n` is low, `pdm_clk_o` is 0, `mic_valid_o` is 0 and every bit of `mic_bit_o` is 0.
- R3: Bit `2p` of `mic_bit_o` (the even microphone of pair `p`) is the value of `pdm_data_i[p]` at the last system cycle of the low phase. That is the cycle just before `pdm_clk_o` rises.
- R4: Bit `2p+1` of `mic_bit_o` (the odd microphone of pair `p`) is the value of `pdm_data_i[p]` at the last system cycle of the high phase. That is the cycle just before `pdm_clk_o` falls.
- R5: `mic_valid_o` is high for exactly one system cycle per bit-clock period. That cycle is the first cycle after `pdm_clk_o` falls. Both bits of every pair are updated in that cycle, and both come from the period that just ended.
- R6: After reset, `mic_valid_o` first goes high at system cycle `DIV`, counting the first cycle after release as cycle 0. No valid pulse comes earlier.
- R7: `mic_bit_o` holds its value in every cycle where `mic_valid_o` is low.
- R8: The value of `pdm_data_i` in any cycle other than the two sampling cycles of a period has no effect on `mic_bit_o`.
- R9: Each data line affects only the two output bits of its own pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pdm_data_i | input | N_PAIRS | One shared data line per microphone pair |
| pdm_clk_o | output | 1 | Bit clock to all microphones |
| mic_bit_o | output | 2*N_PAIRS | Recovered bits: bit 2p is the low-phase microphone of pair p, bit 2p+1 is the high-phase microphone |
| mic_valid_o | output | 1 | One-cycle strobe, once per bit-clock period, when mic_bit_o updates |

## Verification
Some properties are checked by assertions on every cycle:
- the bit clock's half-period length;
- the timing of the valid pulse relative to the clock's falling edge;
- the earliest valid pulse after reset;
- the odd microphone bits matching the line value one cycle before the valid pulse;
- the stability of the outputs between valid pulses.

The bench scenarios cover the rest. The even-microphone sampling point lies half a period back, so only the bench checks it. The bench also shows that data toggled outside the sampling cycles is ignored, that the pairs are independent, and that the block behaves correctly across a reset in the middle of a run. For this it drives random, constant, alternating and deliberately glitching line patterns.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;
    // Sampling point selected by the bit-clock generator in a given cycle
    typedef enum logic [1:0] {
        TAP_NONE     = 2'd0,
        TAP_LOW_END  = 2'd1,
        TAP_HIGH_END = 2'd2
    } tap_e;
endpackage

// File: rtl/pdm_bitclk_gen.sv
module pdm_bitclk_gen
    import pdm_cap_pkg::*;
#(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic bitclk_o,
    output tap_e tap_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST_LOW  = CW'(DIV / 2 - 1);
    localparam logic [CW-1:0] LAST_HIGH = CW'(DIV - 1);
    localparam logic [CW-1:0] FIRST_HI  = CW'(DIV / 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          bitclk;
    } gen_state_t;

    gen_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST_HIGH) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.bitclk = (st_d.cnt >= FIRST_HI);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.cnt == LAST_LOW) begin
            tap_o = TAP_LOW_END;
        end else if (st_q.cnt == LAST_HIGH) begin
            tap_o = TAP_HIGH_END;
        end else begin
            tap_o = TAP_NONE;
        end
    end

    assign bitclk_o = st_q.bitclk;
endmodule

// File: rtl/pdm_pair_split.sv
module pdm_pair_split
    import pdm_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  tap_e tap_i,
    output logic low_bit_o,
    output logic high_bit_o
);
    typedef struct packed {
        logic low_hold;
        logic low_out;
        logic high_out;
    } split_state_t;

    split_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (tap_i)
            TAP_LOW_END: begin
                st_d.low_hold = line_i;
            end
            TAP_HIGH_END: begin
                st_d.low_out  = st_q.low_hold;
                st_d.high_out = line_i;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign low_bit_o  = st_q.low_out;
    assign high_bit_o = st_q.high_out;
endmodule

// File: rtl/pdm_pair_capture.sv
module pdm_pair_capture
    import pdm_cap_pkg::*;
#(
    parameter int N_PAIRS = 4,
    parameter int DIV     = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_PAIRS-1:0]     pdm_data_i,
    output logic                   pdm_clk_o,
    output logic [2*N_PAIRS-1:0]   mic_bit_o,
    output logic                   mic_valid_o
);
    localparam int N_MICS = 2 * N_PAIRS;

    tap_e tap;

    typedef struct packed {
        logic valid;
    } top_state_t;

    top_state_t st_d, st_q;

    pdm_bitclk_gen #(.DIV(DIV)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .bitclk_o (pdm_clk_o),
        .tap_o    (tap)
    );

    logic [N_MICS-1:0] bits;

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        pdm_pair_split u_split (
            .clk        (clk),
            .rst_n      (rst_n),
            .line_i     (pdm_data_i[p]),
            .tap_i      (tap),
            .low_bit_o  (bits[2*p]),
            .high_bit_o (bits[2*p+1])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = (tap == TAP_HIGH_END);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mic_bit_o   = bits;
    assign mic_valid_o = st_q.valid;
endmodule

// File: rtl/pdm_pair_capture_chk.sv
module pdm_pair_capture_chk #(
    parameter int N_PAIRS = 4,
    parameter int DIV     = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_PAIRS-1:0]   pdm_data_i,
    input logic                 pdm_clk_o,
    input logic [2*N_PAIRS-1:0] mic_bit_o,
    input logic                 mic_valid_o
);
    localparam int HALF = DIV / 2;

    logic        prev_clk_q;
    int unsigned run_q;
    int unsigned since_rst_q;
    logic [N_PAIRS-1:0] odd_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_clk_q  <= 1'b0;
            run_q       <= 0;
            since_rst_q <= 0;
        end else begin
            prev_clk_q <= pdm_clk_o;
            run_q      <= (pdm_clk_o != prev_clk_q) ? 1 : run_q + 1;
            if (since_rst_q < DIV) since_rst_q <= since_rst_q + 1;
        end
    end

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_odd
        assign odd_bits[p] = mic_bit_o[2*p+1];
    end

    // R1: each level of the bit clock lasts exactly DIV/2 cycles
    assert_half_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pdm_clk_o != prev_clk_q) |-> (run_q == HALF));

    // R5: a valid pulse only appears right after the bit clock falls
    assert_valid_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mic_valid_o |-> $fell(pdm_clk_o));

    // R6: no valid pulse before a full period has elapsed
    assert_first_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mic_valid_o |-> (since_rst_q >= DIV));

    // R4: odd microphone bits equal the line in the cycle before the pulse
    assert_odd_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mic_valid_o |-> (odd_bits == $past(pdm_data_i)));

    // R7: outputs hold between pulses
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mic_valid_o |-> $stable(mic_bit_o));
endmodule

bind pdm_pair_capture pdm_pair_capture_chk #(
    .N_PAIRS (N_PAIRS),
    .DIV     (DIV)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pdm_data_i  (pdm_data_i),
    .pdm_clk_o   (pdm_clk_o),
    .mic_bit_o   (mic_bit_o),
    .mic_valid_o (mic_valid_o)
);

// File: tb/sim_pdm_pair_capture.sv
`timescale 1ns/1ps
module sim_pdm_pair_capture;
    localparam int NP   = 4;
    localparam int DIV  = 32;
    localparam int HALF = DIV / 2;
    localparam int NM   = 2 * NP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pdm_data_i = '0;
    logic          pdm_clk_o;
    logic [NM-1:0] mic_bit_o;
    logic          mic_valid_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [NP-1:0] lo_ref = '0;
    logic [NP-1:0] hi_ref = '0;
    logic [NM-1:0] exp_bits = '0;
    logic [NM-1:0] last_bits = '0;
    logic [NP-1:0] prev_d = '0;
    logic [NP-1:0] pat = '0;
    bit done = 0;

    always #4 clk = ~clk;

    pdm_pair_capture #(.N_PAIRS(NP), .DIV(DIV)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pdm_data_i  (pdm_data_i),
        .pdm_clk_o   (pdm_clk_o),
        .mic_bit_o   (mic_bit_o),
        .mic_valid_o (mic_valid_o)
    );

    function automatic logic exp_clk(int c);
        return (c % DIV) >= HALF;
    endfunction

    function automatic logic exp_valid(int c);
        return (c >= DIV) && ((c % DIV) == 0);
    endfunction

    function automatic logic [NM-1:0] weave(logic [NP-1:0] lo, logic [NP-1:0] hi);
        logic [NM-1:0] r;
        for (int p = 0; p < NP; p++) begin
            r[2*p]   = lo[p];
            r[2*p+1] = hi[p];
        end
        return r;
    endfunction

    function automatic logic [NM-1:0] pick_even(logic [NM-1:0] v);
        logic [NM-1:0] r = '0;
        for (int p = 0; p < NP; p++) r[2*p] = v[2*p];
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    task automatic reset_check();
        check("R2 clk in reset", 32'(pdm_clk_o), 0);
        check("R2 valid in reset", 32'(mic_valid_o), 0);
        check("R2 bits in reset", 32'(mic_bit_o), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        reset_check();
        rst_n = 1'b1;
        cyc = 0;
        last_bits = '0;
    endtask

    // modes: 0 random, 1 ones, 2 zeros, 3 alternating, 4 glitch outside sample points, 5 single pair active
    task automatic run(int n, int mode);
        for (int i = 0; i < n; i++) begin
            logic [NP-1:0] d;
            int ph;
            ph = cyc % DIV;
            check("R1 bit clock level", 32'(pdm_clk_o), 32'(exp_clk(cyc)));
            check(cyc < DIV ? "R6 no early valid" : "R5 valid pulse",
                  32'(mic_valid_o), 32'(exp_valid(cyc)));
            if (exp_valid(cyc)) begin
                check("R3 even mic bits", 32'(pick_even(mic_bit_o)), 32'(pick_even(exp_bits)));
                check(mode == 4 ? "R8 ignore off-sample data" :
                      (mode == 5 ? "R9 pair isolation" : "R4 odd mic bits"),
                      32'(mic_bit_o), 32'(exp_bits));
                last_bits = exp_bits;
            end else begin
                check("R7 hold between pulses", 32'(mic_bit_o), 32'(last_bits));
            end
            if (ph == 0) pat = NP'($urandom);
            case (mode)
                0: d = NP'($urandom);
                1: d = '1;
                2: d = '0;
                3: d = ~prev_d;
                4: d = (ph == HALF - 1 || ph == DIV - 1) ? pat : ~pat;
                default: d = {{(NP-1){1'b0}}, 1'($urandom)};
            endcase
            pdm_data_i = d;
            prev_d = d;
            if (ph == HALF - 1) lo_ref = d;
            if (ph == DIV - 1) begin
                hi_ref = d;
                exp_bits = weave(lo_ref, hi_ref);
            end
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        @(negedge clk);
        do_reset();
        run(DIV * 20, 0);
        run(DIV * 4, 1);
        run(DIV * 4, 2);
        run(DIV * 4, 3);
        run(DIV * 10, 4);
        run(DIV * 10, 5);
        // reset in mid-period, then resume
        run(DIV / 2 + 3, 0);
        do_reset();
        run(DIV * 10, 0);
        run(DIV * 6, 4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule